// File: doc/BRIEF.md
# Card Command Path Controller

This block sends a single command frame to a memory card over a one-wire, bidirectional command line and, when asked to, collects the card's reply. Software loads a 32-bit argument word, then writes a command word that holds the command index and the reply options. Setting the enable bit in that write launches the frame. The block generates its own card clock from the system clock. It drives the frame out one bit at a time, releases the line, and samples the card's reply.

A reply is either short (48 bits) or long (136 bits). Its payload lands in four 32-bit reply registers. Four sticky flags report how the command ended: frame sent with no reply expected, reply received, no reply within the allowed window, or reply checksum mismatch. A separate clear register resets any chosen flag by writing a one to it. A busy bit is visible while the command is in flight.

Top module: `cmd_path`

## Requirements
- R1: The command word (address 1) carries the index in bits 5:0, the reply-wanted flag in bit 6, the long-reply flag in bit 7 and the enable flag in bit 10. Writing it with bit 10 set starts a frame. Writing it with bit 10 clear starts nothing, so cmd_oe stays low.
- R2: The frame is 48 bits, sent MSB first: a 0 start bit, a 1 direction bit, the 6 index bits, the 32 argument bits (address 0), a CRC7 with polynomial x^7+x^3+1 computed over the first 40 bits, and a 1 stop bit. Each bit changes only on a falling card-clock edge.
- R3: With no reply wanted, releasing the line after the stop bit sets status bit 7 and nothing else.
- R4: A short reply is 48 bits. Its bits 39:8, counted from the last bit received as bit 0, are stored in reply register 0 (address 4). Reply registers 1 to 3 (addresses 5 to 7) read zero. If the received bits 7:1 match the CRC7 of the first 40 bits, status bit 6 is set.
- R5: When a short reply's CRC7 does not match, status bit 0 is set and status bit 6 stays clear.
- R6: A long reply is 136 bits. Its last 128 bits fill reply registers 0 to 3, with the most significant word in register 0. No checksum is checked, and status bit 6 is set.
- R7: The window for the reply start bit is 64 card-clock rising edges after the line is released. A start bit seen on the 64th edge is accepted. If it has not arrived by then, status bit 2 is set and the block goes idle.
- R8: Status bit 11 (address 2) is high from the launch write until the command ends. cmd_oe is high only while this bit is high.
- R9: A write to the clear register (address 3) clears each status flag whose bit is written as one. Flags written as zero keep their value.
- R10: A command word written with enable set while a command is in flight is ignored, and the frame in progress is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| cclk | output | 1 | Card clock |
| cmd_out | output | 1 | Command line drive value |
| cmd_oe | output | 1 | Command line drive enable |
| cmd_in | input | 1 | Command line sampled value |

## Verification
The hardest situation to reach is the exact edge of the reply window. A start bit on the 64th rising edge must be accepted, while one a single card clock later must give a timeout. The bench card model counts falling card-clock edges from the moment the line is released and places the start bit on a chosen edge, so both edge cases are directed runs. A corrupted short-reply checksum is the other case that is hard to reach, and the model flips a CRC bit on demand. A write made while a frame is on the wire is forked in parallel with the frame capture.

// File: rtl/cmd_path.sv
module cmd_path #(
  parameter int CLK_DIV      = 2,
  parameter int TIMEOUT_CLKS = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [2:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        cclk,
  output logic        cmd_out,
  output logic        cmd_oe,
  input  logic        cmd_in
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int TW = $clog2(TIMEOUT_CLKS);

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT, S_RECV} st_t;

  st_t          st;
  logic [DW-1:0] dcnt;
  logic [47:0]  tx;
  logic [5:0]   bcnt;
  logic [TW-1:0] wcnt;
  logic [7:0]   rcnt;
  logic [127:0] sh;
  logic [6:0]   crc;
  logic         want_rsp, want_long;
  logic [31:0]  arg_q;
  logic [10:0]  cmd_q;
  logic [31:0]  rsp [4];
  logic         f_crc, f_to, f_rend, f_sent;

  function automatic logic [6:0] crc_step(input logic [6:0] c, input logic b);
    logic fb;
    fb = c[6] ^ b;
    return {c[5:0], fb} ^ {3'b000, fb, 3'b000};
  endfunction

  function automatic logic [6:0] crc40(input logic [39:0] v);
    logic [6:0] c;
    c = '0;
    for (int i = 39; i >= 0; i--) c = crc_step(c, v[i]);
    return c;
  endfunction

  wire tick      = (dcnt == DW'(CLK_DIV - 1));
  wire fall_tick = tick && cclk;
  wire rise_tick = tick && !cclk;
  wire active    = (st != S_IDLE);
  wire launch    = wr_en && (wr_addr == 3'd1) && wr_data[10] && !active;
  wire [39:0] head = {2'b01, wr_data[5:0], arg_q};
  wire [127:0] nsh = {sh[126:0], cmd_in};
  wire [7:0] last_idx = want_long ? 8'd135 : 8'd47;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt <= '0;
      cclk <= 1'b0;
    end else if (tick) begin
      dcnt <= '0;
      cclk <= !cclk;
    end else begin
      dcnt <= dcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arg_q <= '0;
      cmd_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == 3'd0) arg_q <= wr_data;
      if (wr_addr == 3'd1 && !active) cmd_q <= wr_data[10:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      tx        <= '0;
      bcnt      <= '0;
      wcnt      <= '0;
      rcnt      <= '0;
      sh        <= '0;
      crc       <= '0;
      want_rsp  <= 1'b0;
      want_long <= 1'b0;
      cmd_out   <= 1'b1;
      cmd_oe    <= 1'b0;
      f_crc     <= 1'b0;
      f_to      <= 1'b0;
      f_rend    <= 1'b0;
      f_sent    <= 1'b0;
      for (int i = 0; i < 4; i++) rsp[i] <= '0;
    end else begin
      if (wr_en && wr_addr == 3'd3) begin
        if (wr_data[0]) f_crc  <= 1'b0;
        if (wr_data[2]) f_to   <= 1'b0;
        if (wr_data[6]) f_rend <= 1'b0;
        if (wr_data[7]) f_sent <= 1'b0;
      end
      case (st)
        S_IDLE: if (launch) begin
          tx        <= {head, crc40(head), 1'b1};
          bcnt      <= '0;
          want_rsp  <= wr_data[6];
          want_long <= wr_data[6] && wr_data[7];
          st        <= S_SEND;
        end
        S_SEND: if (fall_tick) begin
          if (bcnt < 6'd48) begin
            cmd_oe  <= 1'b1;
            cmd_out <= tx[47];
            tx      <= {tx[46:0], 1'b0};
            bcnt    <= bcnt + 1'b1;
          end else begin
            cmd_oe  <= 1'b0;
            cmd_out <= 1'b1;
            wcnt    <= '0;
            if (want_rsp) st <= S_WAIT;
            else begin
              st     <= S_IDLE;
              f_sent <= 1'b1;
            end
          end
        end
        S_WAIT: if (rise_tick) begin
          if (!cmd_in) begin
            st   <= S_RECV;
            rcnt <= 8'd1;
            crc  <= '0;
            sh   <= nsh;
          end else if (wcnt == TW'(TIMEOUT_CLKS - 1)) begin
            st   <= S_IDLE;
            f_to <= 1'b1;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        S_RECV: if (rise_tick) begin
          sh   <= nsh;
          rcnt <= rcnt + 1'b1;
          if (rcnt < 8'd40) crc <= crc_step(crc, cmd_in);
          if (rcnt == last_idx) begin
            st <= S_IDLE;
            if (want_long) begin
              rsp[0] <= nsh[127:96];
              rsp[1] <= nsh[95:64];
              rsp[2] <= nsh[63:32];
              rsp[3] <= nsh[31:0];
              f_rend <= 1'b1;
            end else begin
              rsp[0] <= nsh[39:8];
              rsp[1] <= '0;
              rsp[2] <= '0;
              rsp[3] <= '0;
              if (nsh[7:1] == crc) f_rend <= 1'b1;
              else                 f_crc  <= 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  wire [31:0] status = {20'd0, active, 3'd0, f_sent, f_rend, 3'd0, f_to, 1'b0, f_crc};

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = arg_q;
      3'd1:    rd_data = {21'd0, cmd_q};
      3'd2:    rd_data = status;
      3'd4:    rd_data = rsp[0];
      3'd5:    rd_data = rsp[1];
      3'd6:    rd_data = rsp[2];
      3'd7:    rd_data = rsp[3];
      default: rd_data = '0;
    endcase
  end
endmodule

module cmd_path_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [2:0]  wr_addr,
  input logic [31:0] wr_data,
  input logic        cmd_out,
  input logic        cmd_oe,
  input logic        fall_tick,
  input logic        active,
  input logic        f_sent,
  input logic        f_rend,
  input logic        f_to,
  input logic        f_crc
);
  assert_launch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd1 && wr_data[10] && !active) |=> active);
  assert_oe_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> active);
  assert_line_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_tick |=> ($stable(cmd_out) && $stable(cmd_oe)));
  assert_one_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !($rose(f_sent) && $rose(f_rend)));
  assert_crc_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_crc) |-> !$rose(f_rend));
  assert_timeout_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_to) |-> !active);
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd3 && wr_data[7] && !active) |=> !f_sent);
endmodule

bind cmd_path cmd_path_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .cmd_out(cmd_out), .cmd_oe(cmd_oe), .fall_tick(fall_tick), .active(active),
  .f_sent(f_sent), .f_rend(f_rend), .f_to(f_to), .f_crc(f_crc)
);

// File: tb/cmd_path_bench.sv
`timescale 1ns/1ps
module cmd_path_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        cclk, cmd_out, cmd_oe;
  logic        cmd_in = 1'b1;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  cmd_path u_cmd_path (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cclk(cclk), .cmd_out(cmd_out),
    .cmd_oe(cmd_oe), .cmd_in(cmd_in)
  );

  always #2.5 clk = !clk;

  function automatic logic [6:0] ref_crc(input logic [39:0] v);
    logic [6:0] r;
    logic x;
    r = 7'd0;
    for (int i = 39; i >= 0; i--) begin
      x = v[i] ^ r[6];
      r = r << 1;
      r[0] = x;
      r[3] = r[3] ^ x;
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    #0.5;
    d = rd_data;
  endtask

  // kind: 0 none, 1 short, 2 long
  task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg, input int kind,
                         input int dly, input bit bad, input bit poke, input string req);
    logic [47:0]  fr, efr;
    logic [135:0] rf;
    logic [127:0] lb;
    logic [31:0]  pl, s, exp_st;
    int           len;
    logic [31:0]  cw;
    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd0, arg);
    cw = {21'd0, 1'b1, 2'b00, kind == 2, kind != 0, 6'd0} | {26'd0, idx};
    wr(3'd1, cw);
    rd(3'd2, s);
    chk("R8 busy after launch", s & 32'h800, 32'h800);
    fork
      begin
        wait (cmd_oe);
        for (int i = 0; i < 48; i++) begin
          @(posedge cclk);
          fr = {fr[46:0], cmd_out};
        end
      end
      begin
        if (poke) begin
          repeat (30) @(negedge clk);
          wr(3'd1, 32'h0000_04FF);
        end
      end
    join
    efr = {2'b01, idx, arg, ref_crc({2'b01, idx, arg}), 1'b1};
    chk({req, " R2 frame hi"}, {16'd0, fr[47:32]}, {16'd0, efr[47:32]});
    chk({req, " R2 frame lo"}, fr[31:0], efr[31:0]);
    pl = $urandom;
    lb = {$urandom, $urandom, $urandom, $urandom};
    lb[0] = 1'b1;
    if (kind == 1) begin
      rf = '0;
      rf[47:0] = {2'b00, idx, pl, ref_crc({2'b00, idx, pl}), 1'b1};
      if (bad) rf[3] = !rf[3];
      len = 48;
    end else begin
      rf = {2'b00, 6'h3F, lb};
      len = 136;
    end
    if (kind != 0) begin
      repeat (dly - 1) @(negedge cclk);
      for (int i = len - 1; i >= 0; i--) begin
        @(negedge cclk);
        cmd_in = rf[i];
      end
      @(negedge cclk);
      cmd_in = 1'b1;
    end
    for (int i = 0; i < 2000; i++) begin
      rd(3'd2, s);
      if (!s[11]) break;
    end
    if (kind == 0) exp_st = 32'h80;
    else if (dly > 64) exp_st = 32'h04;
    else if (kind == 1 && bad) exp_st = 32'h01;
    else exp_st = 32'h40;
    chk({req, " status"}, s, exp_st);
    if (kind == 1 && dly <= 64) begin
      rd(3'd4, s); chk({req, " R4 rsp0"}, s, pl);
      rd(3'd5, s); chk({req, " R4 rsp1"}, s, 32'd0);
      rd(3'd7, s); chk({req, " R4 rsp3"}, s, 32'd0);
    end
    if (kind == 2 && dly <= 64) begin
      rd(3'd4, s); chk({req, " R6 rsp0"}, s, lb[127:96]);
      rd(3'd5, s); chk({req, " R6 rsp1"}, s, lb[95:64]);
      rd(3'd6, s); chk({req, " R6 rsp2"}, s, lb[63:32]);
      rd(3'd7, s); chk({req, " R6 rsp3"}, s, lb[31:0]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    void'($urandom(32'h5EED_1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    rd(3'd2, s);
    chk("reset status", s, 32'd0);
    chk("reset line", {30'd0, cmd_oe, cmd_out}, 32'd1);

    // R1: no enable bit -> nothing happens
    wr(3'd1, 32'h0000_00C5);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (cmd_oe) begin chk("R1 no-enable oe", 32'd1, 32'd0); break; end
    end
    rd(3'd2, s);
    chk("R1 no-enable status", s, 32'd0);

    run_cmd(6'd0,  32'h0000_0000, 0, 0, 0, 0, "R1 R3 no-reply");
    run_cmd(6'd17, 32'hA5A5_0F0F, 1, 3, 0, 0, "R4 short");
    run_cmd(6'd9,  32'h1234_5678, 1, 2, 1, 0, "R5 bad crc");
    run_cmd(6'd2,  32'hFFFF_FFFF, 2, 5, 0, 0, "R6 long");
    run_cmd(6'd41, 32'h0BAD_F00D, 1, 64, 0, 0, "R7 edge accept");
    run_cmd(6'd42, 32'h0BAD_F00E, 1, 65, 0, 0, "R7 timeout");
    run_cmd(6'd63, 32'hDEAD_BEEF, 0, 0, 0, 1, "R10 ignored write");

    // R9: partial clear leaves other flags
    run_cmd(6'd5, 32'h0000_0001, 1, 4, 1, 0, "R9 setup");
    run_cmd(6'd6, 32'h0000_0002, 0, 0, 0, 0, "R9 setup2");
    wr(3'd0, 32'd0);
    rd(3'd2, s);
    chk("R9 before clear", s, 32'h80);
    run_cmd(6'd7, 32'h3, 1, 70, 0, 0, "R9 setup3");
    rd(3'd2, s);
    chk("R9 timeout present", s, 32'h04);
    wr(3'd3, 32'h0000_0001);
    rd(3'd2, s);
    chk("R9 zero-bit keeps", s, 32'h04);
    wr(3'd3, 32'h0000_0004);
    rd(3'd2, s);
    chk("R9 one-bit clears", s, 32'h00);

    for (int n = 0; n < 18; n++) begin
      int k, d;
      k = $urandom_range(2, 0);
      d = $urandom_range(20, 1);
      run_cmd(6'($urandom), $urandom, k, d, ($urandom_range(3, 0) == 0), 0, "random");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule